// File: doc/BRIEF.md
# Master Mode Audio Clock Generator

This block produces the serial bit clock and two independent frame clocks, one for the ADC path and one for the DAC path. All three are derived from the master clock that it runs on. A master/slave select decides whether the block owns these clocks. In master mode it drives them and raises an output enable. In slave mode it drops the enable and holds its clock outputs low, so the pad logic can hand the pins to an external clock source.

Each path has its own 3-bit ratio code. The code sets the frame length in master clock cycles, and the frame clock is low for the first half of a frame and high for the second. The DAC code set includes two short frames that the ADC set lacks. Any code outside a path's set selects a 256-cycle frame. The bit clock follows the DAC ratio and gives 64 bit periods per frame. Each of its falling edges at a frame boundary coincides with a DAC frame clock transition. A new ratio code is adopted only at that path's next frame boundary.

Top module: `aclk_master_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, clk_oe_o, bclk_o, adc_fclk_o and dac_fclk_o are all 0.
- R2: clk_oe_o equals the value master_i had at the previous rising clock edge. Whenever clk_oe_o is 0, bclk_o, adc_fclk_o and dac_fclk_o are all 0.
- R3: The DAC frame lasts N master clock cycles, with N = 128, 192, 256, 384, 512 or 768 for dac_rate_i = 000, 001, 010, 011, 100 or 101. dac_fclk_o is low for N/2 cycles and then high for N/2 cycles.
- R4: The ADC frame lasts N master clock cycles, with N = 256, 384, 512 or 768 for adc_rate_i = 010, 011, 100 or 101. adc_fclk_o is low for N/2 cycles and then high for N/2 cycles.
- R5: The unsupported codes select N = 256: adc_rate_i = 000, 001, 110 and 111, and dac_rate_i = 110 and 111.
- R6: With D = N_dac/64, every bit clock period is low for ceil(D/2) cycles and then high for floor(D/2) cycles. Exactly 64 bit clock falling edges occur per DAC frame.
- R7: Every transition of dac_fclk_o while clk_oe_o stays 1 happens on the same clock edge as a falling edge of bclk_o.
- R8: A ratio code change made during a frame does not alter that frame. The new length takes effect from the next frame boundary of the same path.
- R9: When both paths select the same frame length from the moment master mode is entered, adc_fclk_o and dac_fclk_o are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode |
| adc_rate_i | input | 3 | ADC frame ratio code |
| dac_rate_i | input | 3 | DAC frame ratio code |
| bclk_o | output | 1 | Bit clock, 64 periods per DAC frame |
| adc_fclk_o | output | 1 | ADC frame clock |
| dac_fclk_o | output | 1 | DAC frame clock |
| clk_oe_o | output | 1 | Enable for the clock pin drivers |

## Verification
The assertions take master_i and the ratio codes to be synchronous to the master clock. They expect a ratio code to be held at least until the frame boundary that adopts it. The length properties also assume that master mode, once entered, lasts long enough for whole frames to complete. The stimulus changes inputs only on falling clock edges. It sets the codes while the block is in slave mode, or once during the second half of a frame. It then stays in master mode for several of the longest frames before returning to slave mode.

// File: rtl/aclk_master_gen_pkg.sv
package aclk_master_gen_pkg;

    localparam int MAX_RATIO      = 768;
    localparam int BITS_PER_FRAME = 64;
    localparam int RATIO_W        = $clog2(MAX_RATIO + 1);
    localparam int DIV_W          = $clog2(MAX_RATIO / BITS_PER_FRAME + 1);
    localparam int DIV_SHIFT      = $clog2(BITS_PER_FRAME);

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [DIV_W-1:0]   div_t;
    typedef logic [2:0]         rate_code_t;

    // Frame length in master clock cycles for one ratio code.
    function automatic ratio_t decode_ratio(rate_code_t code, logic wide_set);
        ratio_t r;
        case (code)
            3'b000:  r = wide_set ? ratio_t'(128) : ratio_t'(256);
            3'b001:  r = wide_set ? ratio_t'(192) : ratio_t'(256);
            3'b010:  r = ratio_t'(256);
            3'b011:  r = ratio_t'(384);
            3'b100:  r = ratio_t'(512);
            3'b101:  r = ratio_t'(768);
            default: r = ratio_t'(256);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aclk_ratio_dec.sv
module aclk_ratio_dec
    import aclk_master_gen_pkg::*;
#(
    parameter bit WIDE_SET = 1'b0
) (
    input  rate_code_t code_i,
    output ratio_t     ratio_o
);

    always_comb begin
        ratio_o = decode_ratio(code_i, WIDE_SET);
    end

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div
    import aclk_master_gen_pkg::*;
#(
    parameter bit WIDE_SET = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  rate_code_t code_i,
    output logic       fclk_o,
    output logic       restart_o,
    output ratio_t     ratio_next_o
);

    typedef struct packed {
        ratio_t cnt;
        ratio_t ratio;
        logic   fclk;
    } frame_st_t;

    frame_st_t st_d, st_q;
    ratio_t    ratio_new;
    logic      wrap;

    aclk_ratio_dec #(
        .WIDE_SET (WIDE_SET)
    ) u_dec (
        .code_i  (code_i),
        .ratio_o (ratio_new)
    );

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == st_q.ratio - ratio_t'(1));
        if (!run_i || wrap) begin
            // Frame boundary (or idle): adopt the newly selected length.
            st_d.cnt   = '0;
            st_d.ratio = ratio_new;
            st_d.fclk  = 1'b0;
        end else begin
            st_d.cnt  = st_q.cnt + ratio_t'(1);
            st_d.fclk = (st_d.cnt >= (st_q.ratio >> 1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.ratio <= ratio_t'(256);
            st_q.fclk  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fclk_o       = st_q.fclk;
    assign restart_o    = (st_d.cnt == '0);
    assign ratio_next_o = st_d.ratio;

    p_cnt_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < st_q.ratio);

    p_ratio_frame_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt != '0) |-> $stable(st_q.ratio));

    p_ratio_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ratio == ratio_t'(256)) || (st_q.ratio == ratio_t'(384)) ||
        (st_q.ratio == ratio_t'(512)) || (st_q.ratio == ratio_t'(768)) ||
        (WIDE_SET && ((st_q.ratio == ratio_t'(128)) || (st_q.ratio == ratio_t'(192)))));

endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div
    import aclk_master_gen_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   restart_i,
    input  ratio_t ratio_i,
    output logic   bclk_o
);

    typedef struct packed {
        div_t bcnt;
        div_t div;
        logic bclk;
    } bit_st_t;

    bit_st_t st_d, st_q;
    div_t    div_new;

    always_comb begin
        div_new = div_t'(ratio_i >> DIV_SHIFT);
        st_d    = st_q;
        if (restart_i) begin
            st_d.bcnt = '0;
            st_d.div  = div_new;
        end else if (st_q.bcnt == st_q.div - div_t'(1)) begin
            st_d.bcnt = '0;
        end else begin
            st_d.bcnt = st_q.bcnt + div_t'(1);
        end
        // Low for the first ceil(div/2) cycles of each bit period.
        st_d.bclk = (st_d.bcnt >= ((st_d.div + div_t'(1)) >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.bcnt <= '0;
            st_q.div  <= div_t'(4);
            st_q.bclk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;

    p_bcnt_in_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.bcnt < st_q.div);

    p_fall_starts_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.bclk) |-> (st_q.bcnt == '0));

    p_div_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.div >= div_t'(2)) && (st_q.div <= div_t'(12)));

endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen
    import aclk_master_gen_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       master_i,
    input  logic [2:0] adc_rate_i,
    input  logic [2:0] dac_rate_i,
    output logic       bclk_o,
    output logic       adc_fclk_o,
    output logic       dac_fclk_o,
    output logic       clk_oe_o
);

    localparam int N_PATH  = 2;
    localparam int DAC_IDX = 1;

    typedef struct packed {
        logic oe;
    } top_st_t;

    top_st_t            st_d, st_q;
    rate_code_t         codes   [N_PATH];
    logic [N_PATH-1:0]  fclk;
    logic [N_PATH-1:0]  restart;
    ratio_t             rnext   [N_PATH];

    assign codes[0]       = adc_rate_i;
    assign codes[DAC_IDX] = dac_rate_i;

    for (genvar ch = 0; ch < N_PATH; ch++) begin : g_path
        localparam bit WIDE = (ch == DAC_IDX);

        aclk_frame_div #(
            .WIDE_SET (WIDE)
        ) u_frame (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .run_i        (master_i),
            .code_i       (codes[ch]),
            .fclk_o       (fclk[ch]),
            .restart_o    (restart[ch]),
            .ratio_next_o (rnext[ch])
        );

        p_restart_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            restart[ch] |=> !fclk[ch]);

        p_next_len_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rnext[ch] >= ratio_t'(128)) && (rnext[ch] <= ratio_t'(MAX_RATIO)));
    end

    aclk_bit_div u_bit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart[DAC_IDX]),
        .ratio_i   (rnext[DAC_IDX]),
        .bclk_o    (bclk_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = master_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.oe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_oe_o   = st_q.oe;
    assign adc_fclk_o = fclk[0];
    assign dac_fclk_o = fclk[DAC_IDX];

    p_oe_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        master_i |=> clk_oe_o);

    p_oe_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !master_i |=> !clk_oe_o);

    p_slave_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clk_oe_o |-> (!bclk_o && !adc_fclk_o && !dac_fclk_o));

    p_bclk_fall_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_oe_o && $past(clk_oe_o) && !$stable(dac_fclk_o)) |-> (!bclk_o && $past(bclk_o)));

endmodule

// File: tb/aclk_master_gen_tb.sv
module aclk_master_gen_tb;

    logic       clk;
    logic       rst_n;
    logic       master;
    logic [2:0] adc_rate;
    logic [2:0] dac_rate;
    logic       bclk, adc_fclk, dac_fclk, clk_oe;

    int checks   = 0;
    int failures = 0;

    aclk_master_gen u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .master_i   (master),
        .adc_rate_i (adc_rate),
        .dac_rate_i (dac_rate),
        .bclk_o     (bclk),
        .adc_fclk_o (adc_fclk),
        .dac_fclk_o (dac_fclk),
        .clk_oe_o   (clk_oe)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Scoreboard: expected half-frame lengths per path.
    int    q_adc[$];
    int    q_dac[$];
    string tag_a = "R4";
    string tag_d = "R3";
    int    exp_lo, exp_hi;
    bit    bclk_chk, eq_chk;
    int    bclk_bad, fall_bad, align_bad, eq_bad;
    int    a_rises, d_rises;

    task automatic check(bit ok, string req, int got, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", req, got, expv);
        end
    endtask

    function automatic int exp_ratio(logic [2:0] c, bit dac_set);
        case (c)
            3'b000:  return dac_set ? 128 : 256;
            3'b001:  return dac_set ? 192 : 256;
            3'b010:  return 256;
            3'b011:  return 384;
            3'b100:  return 512;
            3'b101:  return 768;
            default: return 256;
        endcase
    endfunction

    // Monitor
    int   a_len, d_len, b_len, fall_cnt;
    bit   a_first, d_first, b_first, fall_arm;
    logic a_prev = 1'b0, d_prev = 1'b0, b_prev = 1'b0, oe_prev = 1'b0;

    always @(negedge clk) begin
        int e;
        if (!clk_oe) begin
            a_first = 1; d_first = 1; b_first = 1;
            a_len = 0; d_len = 0; b_len = 0;
            fall_arm = 0; fall_cnt = 0;
        end else begin
            if (adc_fclk == a_prev) a_len++;
            else begin
                if (!a_first && q_adc.size() > 0) begin
                    e = q_adc.pop_front();
                    check(a_len == e, tag_a, a_len, e);
                end
                a_first = 0; a_len = 1;
                if (adc_fclk) a_rises++;
            end
            if (dac_fclk == d_prev) d_len++;
            else begin
                if (!d_first && q_dac.size() > 0) begin
                    e = q_dac.pop_front();
                    check(d_len == e, tag_d, d_len, e);
                end
                d_first = 0; d_len = 1;
                if (dac_fclk) d_rises++;
            end
            if (bclk == b_prev) b_len++;
            else begin
                if (!b_first && bclk_chk && (b_prev ? (b_len != exp_hi) : (b_len != exp_lo)))
                    bclk_bad++;
                b_first = 0; b_len = 1;
            end
            if (b_prev && !bclk) fall_cnt++;
            if (dac_fclk && !d_prev) begin
                if (fall_arm && bclk_chk && fall_cnt != 64) fall_bad++;
                fall_cnt = 0; fall_arm = 1;
            end
            if (oe_prev && (dac_fclk != d_prev) && !(b_prev && !bclk)) align_bad++;
            if (eq_chk && (adc_fclk != dac_fclk)) eq_bad++;
        end
        a_prev = adc_fclk; d_prev = dac_fclk; b_prev = bclk; oe_prev = clk_oe;
    end

    task automatic go_slave_and_check();
        master = 1'b0;
        @(negedge clk);
        check(!clk_oe, "R2 oe low in slave", int'(clk_oe), 0);
        check(!bclk && !adc_fclk && !dac_fclk, "R2 clocks quiet in slave",
              int'({bclk, adc_fclk, dac_fclk}), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic prepare(logic [2:0] a, logic [2:0] d, string ta, string td,
                           int na_old, logic [2:0] a_old, int nd_old, logic [2:0] d_old);
        int ra, rd;
        ra = exp_ratio(a, 0);
        rd = exp_ratio(d, 1);
        q_adc.delete(); q_dac.delete();
        for (int i = 0; i < na_old; i++) q_adc.push_back(exp_ratio(a_old, 0) / 2);
        for (int i = 0; i < nd_old; i++) q_dac.push_back(exp_ratio(d_old, 1) / 2);
        for (int i = 0; i < 200; i++) q_adc.push_back(ra / 2);
        for (int i = 0; i < 200; i++) q_dac.push_back(rd / 2);
        tag_a = ta; tag_d = td;
        exp_lo = (rd / 64 + 1) / 2;
        exp_hi = (rd / 64) / 2;
        bclk_bad = 0; fall_bad = 0; align_bad = 0; eq_bad = 0;
        a_rises = 0; d_rises = 0;
    endtask

    task automatic enter_master();
        @(negedge clk);
        master = 1'b1;
        @(negedge clk);
        check(clk_oe, "R2 oe high in master", int'(clk_oe), 1);
    endtask

    task automatic session(logic [2:0] a, logic [2:0] d, string ta, string td);
        adc_rate = a; dac_rate = d;
        prepare(a, d, ta, td, 0, a, 0, d);
        bclk_chk = 1;
        eq_chk = (exp_ratio(a, 0) == exp_ratio(d, 1));
        enter_master();
        repeat (4 * 768) @(negedge clk);
        check(q_adc.size() <= 197, {ta, " adc frames seen"}, 200 - q_adc.size(), 3);
        check(q_dac.size() <= 197, {td, " dac frames seen"}, 200 - q_dac.size(), 3);
        check(bclk_bad == 0, "R6 bit clock low/high lengths", bclk_bad, 0);
        check(fall_bad == 0, "R6 64 bit clock falls per frame", fall_bad, 0);
        check(align_bad == 0, "R7 frame edge on bit clock fall", align_bad, 0);
        if (eq_chk) check(eq_bad == 0, "R9 equal ratios identical frames", eq_bad, 0);
        eq_chk = 0;
        go_slave_and_check();
    endtask

    // Change a ratio code after the k-th rising frame edge of one path.
    task automatic change_session(bit on_dac, logic [2:0] c_old, logic [2:0] c_new, int k);
        int guard;
        bclk_chk = 0; eq_chk = 0;
        if (on_dac) begin
            adc_rate = 3'b010; dac_rate = c_old;
            prepare(3'b010, c_new, "R4", "R8 dac change", 0, 3'b010, 2 * k - 1, c_old);
        end else begin
            dac_rate = 3'b010; adc_rate = c_old;
            prepare(c_new, 3'b010, "R8 adc change", "R3", 2 * k - 1, c_old, 0, 3'b010);
        end
        enter_master();
        guard = 0;
        while (((on_dac ? d_rises : a_rises) < k) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 20000, "R8 frame edge reached", guard, 0);
        if (on_dac) dac_rate = c_new; else adc_rate = c_new;
        repeat (4 * 768) @(negedge clk);
        check(align_bad == 0, "R7 frame edge on bit clock fall", align_bad, 0);
        if (on_dac) check(q_dac.size() <= 197, "R8 dac runs seen", 200 - q_dac.size(), 3);
        else        check(q_adc.size() <= 197, "R8 adc runs seen", 200 - q_adc.size(), 3);
        go_slave_and_check();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; master = 1'b0; adc_rate = 3'b010; dac_rate = 3'b010;
        bclk_chk = 0; eq_chk = 0;
        repeat (3) @(negedge clk);
        check(!clk_oe && !bclk && !adc_fclk && !dac_fclk, "R1 outputs low in reset",
              int'({clk_oe, bclk, adc_fclk, dac_fclk}), 0);
        master = 1'b1;
        @(negedge clk);
        check(!clk_oe && !bclk && !adc_fclk && !dac_fclk, "R1 reset dominates master",
              int'({clk_oe, bclk, adc_fclk, dac_fclk}), 0);
        master = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!clk_oe && !bclk && !adc_fclk && !dac_fclk, "R1 first cycle after reset",
              int'({clk_oe, bclk, adc_fclk, dac_fclk}), 0);
        adc_rate = 3'b101; dac_rate = 3'b000;
        repeat (40) @(negedge clk);
        check(!clk_oe && !bclk && !adc_fclk && !dac_fclk, "R2 slave mode stays quiet",
              int'({clk_oe, bclk, adc_fclk, dac_fclk}), 0);

        session(3'b010, 3'b010, "R4", "R3");
        session(3'b011, 3'b000, "R4", "R3");
        session(3'b100, 3'b001, "R4", "R3");
        session(3'b101, 3'b011, "R4", "R3");
        session(3'b100, 3'b100, "R4", "R3");
        session(3'b011, 3'b101, "R4", "R3");
        session(3'b000, 3'b110, "R5", "R5");
        session(3'b001, 3'b111, "R5", "R5");
        session(3'b111, 3'b010, "R5", "R3");
        session(3'b110, 3'b011, "R5", "R3");
        change_session(1'b1, 3'b010, 3'b000, 3);
        change_session(1'b1, 3'b001, 3'b101, 2);
        change_session(1'b0, 3'b011, 3'b101, 3);
        change_session(1'b0, 3'b101, 3'b010, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule